// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front-End

This block is the slave side of a small three-wire serial memory. A host drives chip select, serial clock and serial data in. The block finds the start bit and shifts in a 2-bit command code and an 8-bit word address. For a store command it also shifts in a 16-bit word. Reads are served from an internal 256 x 16 array, and the word is shifted back on the single data-out line. A store is committed on the last data edge. A down-counter of `WR_CYCLES` system clocks then stands in for the nonvolatile programming time.

All three host inputs pass through two-flop synchronisers into one system clock domain. Serial-clock rising edges are detected on the synchronised copy. Dropping chip select cancels a read at any point. It also cancels a store at any point before the 27th serial-clock rise, counted with the start bit as rise 1. Once that rise is seen, the store runs to completion whatever chip select does. The start detector also treats one condition as a start bit: chip select rising while the serial clock and data in are both already high. In that case the next serial-clock rise carries the first command bit.

The states are IDLE, OPCODE, ADDR, WDATA, RDOUT, WBUSY and DISCARD. The transitions are:
- IDLE to OPCODE on a start hit.
- OPCODE to ADDR on a read or store code, and OPCODE to DISCARD on any other code.
- ADDR to RDOUT for a read, and ADDR to WDATA for a store.
- WDATA to WBUSY on rise 27.
- WBUSY to IDLE when the timer expires.
- OPCODE, ADDR, WDATA, RDOUT and DISCARD to IDLE when chip select is low.

Top module: `mw_eeprom_front`

## Requirements
- R1: A frame is a start bit, then a 2-bit code, then an 8-bit address MSB first, then (for a store) 16 data bits MSB first, all sampled on serial-clock rises. Code 2'b10 reads and code 2'b01 stores.
- R2: A start bit is a 1 on data-in at a serial-clock rise while chip select is high. Zeros clocked before it are skipped. Raising chip select while the serial clock is low, or while data-in is low, does not by itself start a frame.
- R3: Raising chip select while the serial clock and data-in are both high counts as the start bit. The next serial-clock rise then carries the first code bit.
- R4: On a read, data-out is 0 (a dummy bit) after the last address rise. It then shows the 16 data bits MSB first, each changing after a serial-clock rise. After that it stays 0, even with further rises and ones on data-in, until chip select falls.
- R5: On the 27th serial-clock rise of a store frame, the word is stored and data-out goes low (busy).
- R6: Chip select falling before the 27th rise of a store frame leaves the array unchanged and the block not busy.
- R7: After the commit, chip select falling does not abort the store. Busy lasts `WR_CYCLES` system clocks, then the block returns to idle.
- R8: While busy, data-out is low. When idle, data-out is high (ready).
- R9: Frames sent while busy are ignored and change no array word.
- R10: Chip select falling at any point of a read returns the block to idle with data-out high. The next read is correct.
- R11: Codes 2'b00 and 2'b11 are ignored until chip select falls. No array word changes and data-out stays high.
- R12: After reset, every array word is 0, data-out is high and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select from host, active high, asynchronous |
| sk_i | input | 1 | Serial clock from host, asynchronous |
| di_i | input | 1 | Serial data from host |
| do_o | output | 1 | Serial data / ready-busy status to host |

## Verification
Every serial-side result is due at most four system clocks after the serial-clock rise that causes it: two synchroniser flops, the edge detect and one state register. The bench holds each serial-clock phase for four system clocks, drives on falling system-clock edges and samples data-out only after a full phase has elapsed. Busy is checked at three points:
- low shortly after the commit;
- still low 12 clocks before `WR_CYCLES` runs out;
- high 8 clocks after it.

These points bracket the expiry with margin for the synchroniser latency. Array contents are checked through complete read frames against a shadow array, and only after ready has returned.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDOUT,
        ST_WBUSY,
        ST_DISCARD
    } fe_state_t;

    localparam int OP_W = 2;
    localparam logic [OP_W-1:0] OP_READ  = 2'b10;
    localparam logic [OP_W-1:0] OP_STORE = 2'b01;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_wr_timer.sv
module mw_wr_timer #(
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(WR_CYCLES + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= TW'(WR_CYCLES - 1);
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);
endmodule

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front
    import mw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o
);
    localparam int OP_LAST   = 1 + OP_W;
    localparam int ADDR_LAST = OP_LAST + ADDR_W;
    localparam int DATA_LAST = ADDR_LAST + DATA_W;
    localparam int CNT_W     = $clog2(DATA_LAST + 1);

    logic cs_s, sk_s, di_s;
    logic cs_q, sk_q;
    logic cs_rise, sk_rise, start_hit;

    fe_state_t state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nx;
    logic [OP_W-1:0]   op_r;
    logic [OP_W-1:0]   op_full;
    logic [ADDR_W-1:0] addr_r;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] data_r;
    logic [DATA_W-1:0] data_nx;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W:0]   shreg;
    logic mem_we, rd_load;
    logic tmr_busy, tmr_done;

    mw_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_i, sk_i, di_i}),
        .q     ({cs_s, sk_s, di_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs_s;
            sk_q <= sk_s;
        end
    end

    assign sk_rise   = sk_s && !sk_q;
    assign cs_rise   = cs_s && !cs_q;
    // a genuine start edge, or CS rising onto an already high SK and DI
    assign start_hit = cs_s && di_s && (sk_rise || (cs_rise && sk_s));
    assign cnt_nx    = cnt + 1'b1;
    assign op_full   = {op_r[OP_W-2:0], di_s};
    assign rd_addr   = {addr_r[ADDR_W-2:0], di_s};
    assign data_nx   = {data_r[DATA_W-2:0], di_s};

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr_r),
        .wdata (data_nx),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    mw_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mem_we),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    always_comb begin
        state_n = state;
        mem_we  = 1'b0;
        rd_load = 1'b0;
        unique case (state)
            ST_IDLE:
                if (start_hit) state_n = ST_OPCODE;
            ST_OPCODE:
                if (!cs_s) state_n = ST_IDLE;
                else if (sk_rise && cnt_nx == CNT_W'(OP_LAST))
                    state_n = (op_full == OP_READ || op_full == OP_STORE)
                              ? ST_ADDR : ST_DISCARD;
            ST_ADDR:
                if (!cs_s) state_n = ST_IDLE;
                else if (sk_rise && cnt_nx == CNT_W'(ADDR_LAST)) begin
                    if (op_r == OP_STORE) state_n = ST_WDATA;
                    else begin
                        state_n = ST_RDOUT;
                        rd_load = 1'b1;
                    end
                end
            ST_WDATA:
                if (!cs_s) state_n = ST_IDLE;
                else if (sk_rise && cnt_nx == CNT_W'(DATA_LAST)) begin
                    state_n = ST_WBUSY;
                    mem_we  = 1'b1;
                end
            ST_RDOUT, ST_DISCARD:
                if (!cs_s) state_n = ST_IDLE;
            ST_WBUSY:
                if (tmr_done) state_n = ST_IDLE;
            default:
                state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            op_r   <= '0;
            addr_r <= '0;
            data_r <= '0;
            shreg  <= '0;
        end else begin
            if (state == ST_IDLE && start_hit) cnt <= CNT_W'(1);
            else if (sk_rise && (state == ST_OPCODE || state == ST_ADDR
                                 || state == ST_WDATA)) cnt <= cnt_nx;
            if (sk_rise) begin
                if (state == ST_OPCODE) op_r   <= op_full;
                if (state == ST_ADDR)   addr_r <= rd_addr;
                if (state == ST_WDATA)  data_r <= data_nx;
                if (state == ST_RDOUT)  shreg  <= {shreg[DATA_W-1:0], 1'b0};
            end
            if (rd_load) shreg <= {1'b0, rd_data};
        end
    end

    always_comb begin
        unique case (state)
            ST_RDOUT: do_o = shreg[DATA_W];
            ST_WBUSY: do_o = 1'b0;
            default:  do_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/mw_eeprom_front_chk.sv
module mw_eeprom_front_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input fe_state_t state,
    input logic      mem_we,
    input logic      tmr_busy,
    input logic      tmr_done,
    input logic      do_o
);
    // R5
    commit_enters_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_WBUSY && tmr_busy));

    // R5
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(mem_we));

    // R7
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBUSY && !tmr_done && !cs_s) |=> (state == ST_WBUSY));

    // R8
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !do_o);

    // R9
    busy_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !mem_we);

    // R10
    read_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDOUT && !cs_s) |=> (state == ST_IDLE && do_o));
endmodule

bind mw_eeprom_front mw_eeprom_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .state    (state),
    .mem_we   (mem_we),
    .tmr_busy (tmr_busy),
    .tmr_done (tmr_done),
    .do_o     (do_o)
);

// File: tb/test_mw_eeprom_front.sv
module test_mw_eeprom_front;
    localparam int W = 256;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o;
    int checks = 0;
    int fails = 0;
    logic [15:0] exp_mem [256];

    always #2 clk = ~clk;

    mw_eeprom_front #(.ADDR_W(8), .DATA_W(16), .WR_CYCLES(W)) i_mw_eeprom_front (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        di = b;
        tick(H);
        sk = 1'b1;
        tick(H);
        sk = 1'b0;
    endtask

    task automatic cs_raise(input logic skv, input logic div);
        sk = skv;
        di = div;
        tick(H);
        cs = 1'b1;
        tick(H);
        sk = 1'b0;
        di = 1'b0;
        tick(H);
    endtask

    task automatic cs_drop();
        tick(H);
        cs = 1'b0;
        sk = 1'b0;
        di = 1'b0;
        tick(H);
    endtask

    task automatic send_bits(input logic [26:0] fr, input int n);
        for (int i = 0; i < n; i++) bit_out(fr[26-i]);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!do_o && n < 4000) begin
            tick(1);
            n++;
        end
    endtask

    task automatic read_body(input logic [7:0] a, input string tag);
        logic [15:0] got = '0;
        chk(do_o == 1'b0, "R4 dummy bit", {31'd0, do_o}, 0);
        for (int i = 0; i < 16; i++) begin
            bit_out(1'b0);
            got = {got[14:0], do_o};
        end
        chk(got == exp_mem[a], tag, {16'd0, got}, {16'd0, exp_mem[a]});
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        cs_raise(1'b0, 1'b0);
        send_bits({1'b1, 2'b10, a, 16'h0}, 11);
        read_body(a, tag);
        cs_drop();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        cs_raise(1'b0, 1'b0);
        send_bits({1'b1, 2'b01, a, d}, 27);
        chk(do_o == 1'b0, "R5 busy after commit", {31'd0, do_o}, 0);
        exp_mem[a] = d;
        cs_drop();
        wait_ready();
        chk(do_o == 1'b1, "R7 ready returns", {31'd0, do_o}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R12 reset state
        chk(do_o == 1'b1, "R12 ready after reset", {31'd0, do_o}, 1);
        do_read(8'd1, "R12 array zero");
        do_read(8'd255, "R12 array zero");

        // R1 sweep: stores then reads
        for (int a = 0; a < 256; a += 3)
            do_write(8'(a), 16'((a * 16'h0101) ^ 16'h5A3C ^ (a << 3)));
        for (int a = 0; a < 256; a += 3) do_read(8'(a), "R1 store/read sweep");

        // R7 commit then immediate CS drop, busy length
        cs_raise(1'b0, 1'b0);
        send_bits({1'b1, 2'b01, 8'd5, 16'hBEEF}, 27);
        cs = 1'b0;
        exp_mem[5] = 16'hBEEF;
        tick(4);
        chk(do_o == 1'b0, "R8 busy with CS low", {31'd0, do_o}, 0);
        tick(W - 16);
        chk(do_o == 1'b0, "R7 still busy near end", {31'd0, do_o}, 0);
        tick(20);
        chk(do_o == 1'b1, "R7 ready after WR_CYCLES", {31'd0, do_o}, 1);
        do_read(8'd5, "R7 committed despite CS drop");

        // R6 cancel at every rise count before 27
        for (int k = 4; k <= 26; k++) begin
            cs_raise(1'b0, 1'b0);
            send_bits({1'b1, 2'b01, 8'd9, 16'hC0DE}, k);
            cs_drop();
            chk(do_o == 1'b1, "R6 not busy after cancel", {31'd0, do_o}, 1);
            do_read(8'd9, "R6 array unchanged");
        end

        // R9 frame during busy ignored
        cs_raise(1'b0, 1'b0);
        send_bits({1'b1, 2'b01, 8'd20, 16'h1234}, 27);
        exp_mem[20] = 16'h1234;
        cs = 1'b0;
        tick(2);
        cs = 1'b1;
        tick(2);
        send_bits({1'b1, 2'b01, 8'd22, 16'h7777}, 27);
        chk(do_o == 1'b0, "R9 still busy", {31'd0, do_o}, 0);
        cs_drop();
        wait_ready();
        do_read(8'd22, "R9 ignored frame");
        do_read(8'd20, "R9 first store kept");

        // R10 read cancel at each data position
        for (int k = 0; k <= 16; k++) begin
            cs_raise(1'b0, 1'b0);
            send_bits({1'b1, 2'b10, 8'd3, 16'h0}, 11);
            for (int j = 0; j < k; j++) bit_out(1'b0);
            cs_drop();
            chk(do_o == 1'b1, "R10 idle after read cancel", {31'd0, do_o}, 1);
        end
        do_read(8'd3, "R10 read after cancel");

        // R4 trailing zeros, no restart
        cs_raise(1'b0, 1'b0);
        send_bits({1'b1, 2'b10, 8'd6, 16'h0}, 11);
        read_body(8'd6, "R4 read data");
        bit_out(1'b1);
        bit_out(1'b1);
        chk(do_o == 1'b0, "R4 zero after last bit", {31'd0, do_o}, 0);
        cs_drop();

        // R3 false start: CS rises with SK and DI high
        sk = 1'b1;
        di = 1'b1;
        tick(H);
        cs = 1'b1;
        tick(H);
        sk = 1'b0;
        tick(H);
        send_bits({2'b10, 8'd12, 17'h0}, 10);
        read_body(8'd12, "R3 implicit start");
        cs_drop();

        // R2 CS rise with SK high, DI low; and SK low, DI high
        cs_raise(1'b1, 1'b0);
        send_bits({1'b1, 2'b10, 8'd15, 16'h0}, 11);
        read_body(8'd15, "R2 SK high DI low");
        cs_drop();
        cs_raise(1'b0, 1'b1);
        send_bits({1'b1, 2'b10, 8'd18, 16'h0}, 11);
        read_body(8'd18, "R2 SK low DI high");
        cs_drop();
        cs_raise(1'b0, 1'b0);
        send_bits({3'b000, 1'b1, 2'b10, 8'd21, 13'h0}, 14);
        read_body(8'd21, "R2 leading zeros");
        cs_drop();

        // R11 other codes ignored
        for (int op = 0; op < 4; op += 3) begin
            cs_raise(1'b0, 1'b0);
            send_bits({1'b1, 2'(op), 8'd24, 16'hFFFF}, 27);
            chk(do_o == 1'b1, "R11 no busy", {31'd0, do_o}, 1);
            cs_drop();
            do_read(8'd24, "R11 array unchanged");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule